// File: doc/BRIEF.md
# Asynchronous Serial Adapter

This block connects a byte-wide register bus to one asynchronous serial line pair. A single select line picks between two register pairs: with select low, writes go to the control byte and reads return the status byte; with select high, writes load the transmit holding register and reads return the received character. The system clock is divided down to the bit rate. The transmitter turns each written byte into a framed character in one of eight formats. The receiver finds start bits, collects characters and checks their parity and stop bit.

Each direction has one holding register in front of one shift register. The adapter drives a transmit interrupt, a receive interrupt, a request-to-send level and a break indication. It reports the carrier-detect and clear-to-send inputs in the status byte. Writing divide code 3 places the block in its master-reset state, which is also the state after the `rst` input.

Top module: `async_serial_adapter`

## Requirements
- R1: Control bits 1:0 set the bit period in system clocks: code 0 gives 1, code 1 gives DIV_A (16), code 2 gives DIV_B (64). Transmitted and received bits both use this period.
- R2: Control bits 4:2 set the character format. Codes 0..3 carry 7 data bits, with even parity for codes 0 and 2, odd parity for codes 1 and 3, two stop bits for codes 0 and 1 and one stop bit for codes 2 and 3. Codes 4..7 carry 8 data bits: code 4 has no parity and two stops, code 5 has no parity and one stop, code 6 has even parity and one stop, code 7 has odd parity and one stop. Every frame is a low start bit, then data LSB first, then the parity bit if any, then high stop bits. The idle line is high.
- R3: Status bit 1 (transmit empty) is set after reset and whenever the holding byte moves into the shifter. A data write (select high) clears it.
- R4: Each completed character sets status bit 0 (receive full) and is read with select high. In 7-bit formats bit 7 of the read value is 0. A data read clears status bits 0, 4, 5 and 6.
- R5: Status bit 4 is set when the first stop bit of a character is sampled low. Status bit 6 is set when the received parity bit does not match the format.
- R6: When a character completes while status bit 0 is still set, status bit 5 (overrun) is set and the earlier character is kept.
- R7: In divide-16 and divide-64 modes a start bit is accepted only if the line is still low at the middle of the bit. A shorter low pulse produces no character.
- R8: While control bits 6:5 equal 3, `txd` is held low, `brk_out` is high and no new character starts. A byte written in that state is sent after the code changes, once the current character boundary is reached.
- R9: `rts_out` is high exactly when control bits 6:5 equal 2.
- R10: `tx_irq` is high when control bits 6:5 equal 1 and transmit is empty. `rx_irq` is high when control bit 7 is set and receive full or overrun is set. Status bit 7 is the OR of both requests.
- R11: Status bit 2 shows the `dcd` input and status bit 3 shows the `cts` input.
- R12: Divide code 3, and the `rst` input, put the block into master reset. Status reads 0x02 apart from bits 2 and 3, `txd` stays high, and data writes are ignored until a code other than 3 is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; the value appears on bus_rdata after the next edge |
| bus_sel | input | 1 | 0 selects control (write) or status (read); 1 selects transmit data (write) or receive data (read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| txd | output | 1 | Serial output, high when idle |
| rxd | input | 1 | Serial input |
| cts | input | 1 | Clear-to-send level |
| dcd | input | 1 | Carrier-detect level |
| rts_out | output | 1 | Request-to-send level |
| brk_out | output | 1 | High while break is being sent |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Three conditions are hard to reach from the ports. The first is an overrun, where a second character has to finish while the first is still unread. The bench sends two complete frames back to back with no data read between them, then checks that the first byte is still present. The second is a spurious start: a low pulse shorter than half a bit must be dropped, so the bench drives a four-clock glitch in divide-16 mode and confirms that no character appears. The third is the break release. The bench writes a byte during break, watches the line stay low, and then checks that the byte comes out as a normal frame only after the break code is removed.

// File: rtl/asa_pkg.sv
package asa_pkg;

  localparam int FRAME_MAX = 12;
  localparam int RX_BITS_MAX = 10;

  typedef struct packed {
    logic data8;
    logic par_en;
    logic par_odd;
    logic stop2;
  } frame_fmt_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2
  } rx_state_t;

  function automatic frame_fmt_t decode_fmt(input logic [2:0] code);
    frame_fmt_t f;
    f.data8   = code[2];
    f.par_odd = code[0];
    case (code)
      3'd4, 3'd5: f.par_en = 1'b0;
      default:    f.par_en = 1'b1;
    endcase
    case (code)
      3'd0, 3'd1, 3'd4: f.stop2 = 1'b1;
      default:          f.stop2 = 1'b0;
    endcase
    return f;
  endfunction

  function automatic int div_last(input logic [1:0] code, input int a, input int b);
    case (code)
      2'd1:    return a - 1;
      2'd2:    return b - 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/asa_tick.sv
module asa_tick import asa_pkg::*; #(
  parameter int DIV_A = 16,
  parameter int DIV_B = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int CW = $clog2(DIV_B) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb last = CW'(div_last(div_sel, DIV_A, DIV_B));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/asa_tx.sv
module asa_tx import asa_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       tick,
  input  frame_fmt_t fmt,
  input  logic       hold_valid,
  input  logic [7:0] hold_data,
  input  logic       brk_req,
  output logic       load_ack,
  output logic       brk_on,
  output logic       txd
);
  logic                 busy;
  logic [3:0]           left;
  logic [FRAME_MAX-1:0] sh;
  logic [FRAME_MAX-1:0] frame;
  logic [3:0]           total;
  logic [3:0]           nd;
  logic [7:0]           dbits;
  logic                 txd_q;
  logic                 boundary;

  always_comb begin
    nd    = fmt.data8 ? 4'd8 : 4'd7;
    dbits = fmt.data8 ? hold_data : {1'b0, hold_data[6:0]};
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(nd)) frame[1+i] = dbits[i];
    end
    if (fmt.par_en) frame[int'(nd)+1] = (^dbits) ^ fmt.par_odd;
    total = 4'd2 + nd + {3'b000, fmt.par_en} + {3'b000, fmt.stop2};
  end

  assign boundary = !busy || (left == 4'd0);
  assign load_ack = tick && boundary && hold_valid && !brk_on && !brk_req;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      busy   <= 1'b0;
      left   <= '0;
      sh     <= '1;
      txd_q  <= 1'b1;
      brk_on <= 1'b0;
      txd    <= 1'b1;
    end else begin
      txd <= txd_q & ~brk_on;
      if (brk_req) brk_on <= 1'b1;
      else if (tick && boundary) brk_on <= 1'b0;
      if (tick) begin
        if (boundary) begin
          if (load_ack) begin
            sh    <= {1'b1, frame[FRAME_MAX-1:1]};
            txd_q <= frame[0];
            left  <= total - 4'd1;
            busy  <= 1'b1;
          end else begin
            busy  <= 1'b0;
            txd_q <= 1'b1;
          end
        end else begin
          txd_q <= sh[0];
          sh    <= {1'b1, sh[FRAME_MAX-1:1]};
          left  <= left - 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/asa_rx.sv
module asa_rx import asa_pkg::*; #(
  parameter int DIV_A = 16,
  parameter int DIV_B = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic [1:0] div_sel,
  input  frame_fmt_t fmt,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data,
  output logic       fe,
  output logic       pe
);
  localparam int CW = $clog2(DIV_B) + 1;

  rx_state_t              st;
  logic [CW-1:0]          cnt;
  logic [CW-1:0]          last;
  logic [CW-1:0]          mid;
  logic [RX_BITS_MAX-1:0] bits;
  logic [RX_BITS_MAX-1:0] nb;
  logic [3:0]             idx;
  logic [3:0]             nd;
  logic [3:0]             need;
  logic [7:0]             dat;
  logic                   pbit;
  logic                   sbit;

  always_comb begin
    last = CW'(div_last(div_sel, DIV_A, DIV_B));
    mid  = last >> 1;
    nd   = fmt.data8 ? 4'd8 : 4'd7;
    need = nd + {3'b000, fmt.par_en} + 4'd1;
    nb   = bits;
    if (idx < 4'(RX_BITS_MAX)) nb[idx] = rxd;
    dat  = fmt.data8 ? nb[7:0] : {1'b0, nb[6:0]};
    pbit = nb[nd];
    sbit = nb[nd + {3'b000, fmt.par_en}];
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      idx  <= '0;
      bits <= '0;
      done <= 1'b0;
      data <= '0;
      fe   <= 1'b0;
      pe   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (!rxd) st <= (last == '0) ? RX_DATA : RX_START;
        end
        RX_START: begin
          if (cnt == mid) begin
            cnt <= '0;
            st  <= rxd ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt >= last) begin
            cnt  <= '0;
            bits <= nb;
            if (idx == need - 4'd1) begin
              done <= 1'b1;
              data <= dat;
              fe   <= !sbit;
              pe   <= fmt.par_en && (pbit != ((^dat) ^ fmt.par_odd));
              st   <= RX_IDLE;
            end else begin
              idx <= idx + 4'd1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/async_serial_adapter.sv
module async_serial_adapter import asa_pkg::*; #(
  parameter int DIV_A       = 16,
  parameter int DIV_B       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       txd,
  input  logic       rxd,
  input  logic       cts,
  input  logic       dcd,
  output logic       rts_out,
  output logic       brk_out,
  output logic       tx_irq,
  output logic       rx_irq
);
  logic [7:0] ctrl_q;
  logic       in_reset;
  frame_fmt_t fmt;
  logic       tick;
  logic       load_ack;
  logic       rx_done;
  logic [7:0] rx_data;
  logic       rx_fe;
  logic       rx_pe;
  logic [7:0] tx_hold;
  logic [7:0] rx_hold;
  logic       tx_empty;
  logic       rx_full;
  logic       fe_q;
  logic       pe_q;
  logic       ovr_q;
  logic       irq_any;
  logic [7:0] status;
  logic       rd_data;
  logic       wr_data;

  logic [SYNC_STAGES-1:0] rxd_pipe;
  logic [SYNC_STAGES-1:0] cts_pipe;
  logic [SYNC_STAGES-1:0] dcd_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_pipe <= '1;
      cts_pipe <= '0;
      dcd_pipe <= '0;
    end else begin
      rxd_pipe <= {rxd_pipe[SYNC_STAGES-2:0], rxd};
      cts_pipe <= {cts_pipe[SYNC_STAGES-2:0], cts};
      dcd_pipe <= {dcd_pipe[SYNC_STAGES-2:0], dcd};
    end
  end

  assign in_reset = (ctrl_q[1:0] == 2'd3);
  assign fmt      = decode_fmt(ctrl_q[4:2]);
  assign rd_data  = bus_rd && bus_sel;
  assign wr_data  = bus_wr && bus_sel && !in_reset;

  asa_tick #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_tick (
    .clk(clk), .rst(rst), .clr(in_reset), .div_sel(ctrl_q[1:0]), .tick(tick)
  );

  asa_tx u_tx (
    .clk(clk), .rst(rst), .hold(in_reset), .tick(tick), .fmt(fmt),
    .hold_valid(!tx_empty), .hold_data(tx_hold), .brk_req(ctrl_q[6:5] == 2'd3),
    .load_ack(load_ack), .brk_on(brk_out), .txd(txd)
  );

  asa_rx #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_rx (
    .clk(clk), .rst(rst), .hold(in_reset), .div_sel(ctrl_q[1:0]), .fmt(fmt),
    .rxd(rxd_pipe[SYNC_STAGES-1]), .done(rx_done), .data(rx_data),
    .fe(rx_fe), .pe(rx_pe)
  );

  assign irq_any = (ctrl_q[7] && (rx_full || ovr_q)) ||
                   ((ctrl_q[6:5] == 2'd1) && tx_empty);
  assign status  = {irq_any, pe_q, ovr_q, fe_q,
                    cts_pipe[SYNC_STAGES-1], dcd_pipe[SYNC_STAGES-1],
                    tx_empty, rx_full};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= 8'h03;
      tx_hold   <= '0;
      rx_hold   <= '0;
      tx_empty  <= 1'b1;
      rx_full   <= 1'b0;
      fe_q      <= 1'b0;
      pe_q      <= 1'b0;
      ovr_q     <= 1'b0;
      bus_rdata <= '0;
      rts_out   <= 1'b0;
      tx_irq    <= 1'b0;
      rx_irq    <= 1'b0;
    end else begin
      if (bus_wr && !bus_sel) ctrl_q <= bus_wdata;
      if (bus_rd) bus_rdata <= bus_sel ? rx_hold : status;
      rts_out <= (ctrl_q[6:5] == 2'd2);
      tx_irq  <= (ctrl_q[6:5] == 2'd1) && tx_empty;
      rx_irq  <= ctrl_q[7] && (rx_full || ovr_q);
      if (in_reset) begin
        tx_empty <= 1'b1;
        rx_full  <= 1'b0;
        fe_q     <= 1'b0;
        pe_q     <= 1'b0;
        ovr_q    <= 1'b0;
      end else begin
        if (load_ack) tx_empty <= 1'b1;
        if (wr_data) begin
          tx_hold  <= bus_wdata;
          tx_empty <= 1'b0;
        end
        if (rd_data) begin
          rx_full <= 1'b0;
          fe_q    <= 1'b0;
          pe_q    <= 1'b0;
          ovr_q   <= 1'b0;
        end
        if (rx_done) begin
          if (rx_full && !rd_data) begin
            ovr_q <= 1'b1;
          end else begin
            rx_hold <= rx_data;
            rx_full <= 1'b1;
            fe_q    <= rx_fe;
            pe_q    <= rx_pe;
          end
        end
      end
    end
  end
endmodule

// File: rtl/asa_checker.sv
module asa_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_sel,
  input logic       txd,
  input logic       brk_out,
  input logic       rx_irq,
  input logic [7:0] ctrl_q,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       ovr_q,
  input logic [7:0] rx_hold,
  input logic       rx_done
);
  logic in_reset;
  assign in_reset = (ctrl_q[1:0] == 2'd3);

  a_r12_idle_line_in_reset: assert property (@(posedge clk) disable iff (rst)
    (in_reset && $past(in_reset) && $past(in_reset, 2)) |-> txd);

  a_r8_break_drives_low: assert property (@(posedge clk) disable iff (rst)
    brk_out |=> !txd);

  a_r6_overrun_keeps_old: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $stable(rx_hold));

  a_r3_write_clears_empty: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel && !in_reset) |=> !tx_empty);

  a_r4_read_clears_full: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel && !rx_done) |=> !rx_full);

  a_r10_rx_irq_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq) |-> $past(ctrl_q[7]));
endmodule

bind async_serial_adapter asa_checker u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
  .txd(txd), .brk_out(brk_out), .rx_irq(rx_irq), .ctrl_q(ctrl_q),
  .tx_empty(tx_empty), .rx_full(rx_full), .ovr_q(ovr_q), .rx_hold(rx_hold),
  .rx_done(rx_done)
);

// File: tb/async_serial_adapter_bench.sv
module async_serial_adapter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       txd;
  logic       rxd = 1'b1;
  logic       cts = 1'b0;
  logic       dcd = 1'b0;
  logic       rts_out;
  logic       brk_out;
  logic       tx_irq;
  logic       rx_irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  async_serial_adapter u_async_serial_adapter (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd),
    .cts(cts), .dcd(dcd), .rts_out(rts_out), .brk_out(brk_out),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = sel;
    @(posedge clk);
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] cw(input bit rie, input int txc, input int fm, input int dv);
    return {rie, 2'(txc), 3'(fm), 2'(dv)};
  endfunction

  function automatic bit fm_par(input int fm);
    return !(fm == 4 || fm == 5);
  endfunction

  function automatic void mk_frame(input int fm, input logic [7:0] d,
                                   output logic [11:0] b, output int n);
    int nd;
    int pos;
    bit p;
    nd = (fm >= 4) ? 8 : 7;
    b = '1;
    b[0] = 1'b0;
    pos = 1;
    p = 1'b0;
    for (int i = 0; i < nd; i++) begin
      b[pos] = d[i];
      p = p ^ d[i];
      pos++;
    end
    if (fm_par(fm)) begin
      b[pos] = (fm == 1 || fm == 3 || fm == 7) ? ~p : p;
      pos++;
    end
    n = pos + ((fm == 0 || fm == 1 || fm == 4) ? 2 : 1);
  endfunction

  task automatic tx_capture(input int dv, input int n, output logic [11:0] got);
    int guard;
    got = '1;
    guard = 0;
    while (txd !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    guard = 0;
    while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    repeat (dv / 2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (dv) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic rx_send(input int fm, input int dv, input logic [7:0] d,
                         input bit bad_par, input bit bad_stop);
    logic [11:0] b;
    int n;
    int nd;
    mk_frame(fm, d, b, n);
    nd = (fm >= 4) ? 8 : 7;
    if (bad_par) b[1+nd] = ~b[1+nd];
    if (bad_stop) b[1+nd+(fm_par(fm) ? 1 : 0)] = 1'b0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = b[i];
      repeat (dv) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * dv + 6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [11:0] exp_b;
    logic [11:0] got;
    logic [7:0] vals [4];
    int n;
    int lows;
    int divs [3];
    vals[0] = 8'hA5; vals[1] = 8'h5A; vals[2] = 8'hFF; vals[3] = 8'h01;
    divs[0] = 1; divs[1] = 16; divs[2] = 64;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R12 state after reset
    rd(1'b0, v);
    chk("R12 status after reset", v, 8'h02);
    chk("R12 txd idle after reset", txd, 1'b1);
    chk("R9 rts low after reset", rts_out, 1'b0);
    chk("R10 no irq after reset", {tx_irq, rx_irq}, 2'b00);

    // R2 R4 sweep over all formats at divide 16
    for (int fm = 0; fm < 8; fm++) begin
      wr(1'b0, cw(1'b0, 0, fm, 1));
      for (int k = 0; k < 4; k++) begin
        mk_frame(fm, vals[k], exp_b, n);
        wr(1'b1, vals[k]);
        tx_capture(16, n, got);
        chk($sformatf("R2 tx frame fmt=%0d", fm), got & ((12'd1 << n) - 1), exp_b & ((12'd1 << n) - 1));
        rx_send(fm, 16, vals[k], 1'b0, 1'b0);
        rd(1'b0, v);
        chk($sformatf("R4 rx full no errors fmt=%0d", fm), v & 8'h71, 8'h01);
        rd(1'b1, v);
        chk($sformatf("R4 rx data fmt=%0d", fm), v, (fm >= 4) ? vals[k] : (vals[k] & 8'h7F));
      end
      rd(1'b0, v);
      chk("R4 read clears full", v & 8'h71, 8'h00);
    end

    // R1 divide 1 and divide 64
    for (int j = 0; j < 3; j += 2) begin
      wr(1'b0, cw(1'b0, 0, 7, j));
      mk_frame(7, 8'hC3, exp_b, n);
      wr(1'b1, 8'hC3);
      tx_capture(divs[j], n, got);
      chk($sformatf("R1 tx frame div=%0d", divs[j]), got & ((12'd1 << n) - 1), exp_b & ((12'd1 << n) - 1));
      rx_send(7, divs[j], 8'h3C, 1'b0, 1'b0);
      rd(1'b1, v);
      chk($sformatf("R1 rx data div=%0d", divs[j]), v, 8'h3C);
    end

    // R5 framing and parity errors
    wr(1'b0, cw(1'b0, 0, 5, 1));
    rx_send(5, 16, 8'h81, 1'b0, 1'b1);
    rd(1'b0, v);
    chk("R5 framing error flag", v & 8'h71, 8'h11);
    rd(1'b1, v);
    rd(1'b0, v);
    chk("R4 read clears framing error", v & 8'h71, 8'h00);
    wr(1'b0, cw(1'b0, 0, 6, 1));
    rx_send(6, 16, 8'h6B, 1'b1, 1'b0);
    rd(1'b0, v);
    chk("R5 parity error flag", v & 8'h71, 8'h41);
    rd(1'b1, v);
    chk("R5 data with parity error", v, 8'h6B);

    // R6 overrun
    wr(1'b0, cw(1'b0, 0, 5, 1));
    rx_send(5, 16, 8'h11, 1'b0, 1'b0);
    rx_send(5, 16, 8'h22, 1'b0, 1'b0);
    rd(1'b0, v);
    chk("R6 overrun flagged", v & 8'h71, 8'h21);
    rd(1'b1, v);
    chk("R6 earlier char kept", v, 8'h11);
    rd(1'b0, v);
    chk("R6 overrun cleared by read", v & 8'h71, 8'h00);

    // R7 short low pulse rejected
    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    rd(1'b0, v);
    chk("R7 glitch gives no char", v & 8'h71, 8'h00);

    // R8 break, R3 empty cleared by write
    wr(1'b0, cw(1'b0, 3, 5, 1));
    repeat (40) @(negedge clk);
    chk("R8 brk_out high", brk_out, 1'b1);
    chk("R8 txd low in break", txd, 1'b0);
    wr(1'b1, 8'h96);
    rd(1'b0, v);
    chk("R3 write clears empty", v & 8'h02, 8'h00);
    lows = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (txd === 1'b0) lows++;
    end
    chk("R8 line held low", lows, 300);
    wr(1'b0, cw(1'b0, 0, 5, 1));
    mk_frame(5, 8'h96, exp_b, n);
    tx_capture(16, n, got);
    chk("R8 char sent after break", got & ((12'd1 << n) - 1), exp_b & ((12'd1 << n) - 1));
    chk("R8 brk_out released", brk_out, 1'b0);
    rd(1'b0, v);
    chk("R3 empty after load", v & 8'h02, 8'h02);

    // R9 rts
    wr(1'b0, cw(1'b0, 2, 5, 1));
    repeat (3) @(negedge clk);
    chk("R9 rts high for code 2", rts_out, 1'b1);
    wr(1'b0, cw(1'b0, 1, 5, 1));
    repeat (3) @(negedge clk);
    chk("R9 rts low for code 1", rts_out, 1'b0);

    // R10 interrupts
    chk("R10 tx irq with empty", tx_irq, 1'b1);
    wr(1'b0, cw(1'b1, 0, 5, 1));
    repeat (3) @(negedge clk);
    chk("R10 tx irq off for code 0", tx_irq, 1'b0);
    chk("R10 rx irq idle", rx_irq, 1'b0);
    rx_send(5, 16, 8'h5E, 1'b0, 1'b0);
    chk("R10 rx irq on char", rx_irq, 1'b1);
    rd(1'b0, v);
    chk("R10 status irq bit", v & 8'h81, 8'h81);
    rd(1'b1, v);
    repeat (3) @(negedge clk);
    chk("R10 rx irq cleared", rx_irq, 1'b0);

    // R11 modem inputs
    dcd = 1'b1; cts = 1'b0;
    repeat (4) @(negedge clk);
    rd(1'b0, v);
    chk("R11 dcd shown", v & 8'h0C, 8'h04);
    dcd = 1'b0; cts = 1'b1;
    repeat (4) @(negedge clk);
    rd(1'b0, v);
    chk("R11 cts shown", v & 8'h0C, 8'h08);
    cts = 1'b0;
    repeat (4) @(negedge clk);

    // R12 master reset by control write
    rx_send(5, 16, 8'h77, 1'b0, 1'b0);
    wr(1'b0, 8'h03);
    rd(1'b0, v);
    chk("R12 status in master reset", v, 8'h02);
    wr(1'b1, 8'h55);
    wr(1'b0, cw(1'b0, 0, 5, 1));
    lows = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (txd === 1'b0) lows++;
    end
    chk("R12 write in reset ignored", lows, 0);
    rd(1'b0, v);
    chk("R12 status after leaving reset", v, 8'h02);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule